// File: doc/BRIEF.md
# Extended Capability List Walker

This engine searches the extended part of a PCIe function's configuration space for a capability with a given ID. A caller gives it a target ID and a starting offset in a single start cycle. The engine then fetches 32-bit header words one at a time over a simple read port: an address handshake with valid and ready, followed by a one-cycle response carrying the data. It follows the chain of next pointers until it finds a match, reaches the end of the list, sees an empty list or uses up its read budget.

The starting offset lets a caller continue a search. A header at exactly the starting offset is never reported as a hit. Passing a previous hit back in as the start therefore returns the next instance of the same ID. Results stay on the outputs until the next accepted start. The engine only reads: it does not form configuration packets and it does not look at the legacy capability area.

Top module: `ecap_walker`

## Requirements
- R1: A start (start_valid high while busy is low) begins the walk. The first read goes to the larger of 0x100 and start_offs with its two low bits cleared. rd_valid rises in the cycle after the start.
- R2: At most one read is in flight. rd_valid and rd_addr hold until rd_ready is seen. After an address handshake, rd_valid stays low until the response (rd_resp_valid) arrives. Every read address is dword aligned and at or above 0x100.
- R3: If the first header word is 0x00000000 or 0xFFFFFFFF, the walk ends after that single read with found low.
- R4: The header ID sits in bits [15:0]. A header whose ID equals start_id is a hit only if its offset differs from the aligned start offset. A hit ends the walk with found high and found_offs set to that header's offset.
- R5: On a non-hit, the next pointer is taken from bits [31:20] with its two low bits cleared, and the next read goes there. A cleared pointer below 0x100 ends the walk with found low.
- R6: A walk reads at most WALK_LIMIT (default 480) headers. If the last allowed header is not a hit, the walk ends with found low.
- R7: A start request while busy is high is ignored. The walk in progress and its result are unchanged.
- R8: After reset, busy, done, found and rd_valid are low and found_offs is zero. done, found and found_offs hold their values from the end of a walk until the next accepted start, which clears done.
- R9: done rises and busy falls in the cycle after the response that ends the walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_valid | input | 1 | Start request, taken when busy is low |
| start_id | input | 16 | Capability ID to search for |
| start_offs | input | ADDR_W | Starting offset; a header here is skipped as a hit |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Walk finished; held until the next start |
| found | output | 1 | Last walk ended on a hit |
| found_offs | output | ADDR_W | Offset of the hit, zero when not found |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | ADDR_W | Byte offset of the header word to read |
| rd_resp_valid | input | 1 | Read data valid for one cycle |
| rd_data | input | 32 | Header word returned |

## Verification
The first read request appears in the cycle after an accepted start. The bench records the address of that request and compares it with the expected start position. The walk's outcome is due in the cycle after the response that ends it. The bench timestamps each response it drives on the falling edge and requires done on the very next falling edge. It then checks found, found_offs and the number of reads against a reference walk over the same memory image. After that it waits several more cycles and checks that the result has not moved.

// File: rtl/ecap_walk_pkg.sv
package ecap_walk_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2
   } walk_state_e;

   typedef struct packed {
      logic [11:0] next;
      logic [3:0]  ver;
      logic [15:0] id;
   } ecap_hdr_t;

   localparam logic [11:0] ECAP_FLOOR    = 12'h100;
   localparam logic [15:0] ECAP_ID_SRIOV = 16'h0010;
   localparam int unsigned HDR_W         = 32;
   localparam int unsigned CAPID_W       = 16;

endpackage

// File: rtl/ecap_hdr_split.sv
module ecap_hdr_split
   import ecap_walk_pkg::*;
#(
   parameter int unsigned ADDR_W = 12
) (
   input  logic [HDR_W-1:0]   word,
   output logic [CAPID_W-1:0] cap_id,
   output logic [ADDR_W-1:0]  next_al,
   output logic               empty
);

   ecap_hdr_t hdr;

   generate
      if (ADDR_W < 12) begin : g_bad_width
         $error("ecap_hdr_split: ADDR_W must be at least 12");
      end
   endgenerate

   always_comb begin
      hdr     = ecap_hdr_t'(word);
      cap_id  = hdr.id;
      next_al = ADDR_W'({hdr.next[11:2], 2'b00});
      empty   = (hdr == '0) || (hdr == '1);
   end

endmodule

// File: rtl/ecap_budget.sv
module ecap_budget #(
   parameter int unsigned LIMIT = 480
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic step,
   output logic last
);

   localparam int unsigned CNT_W = $clog2(LIMIT + 1);

   logic [CNT_W-1:0] cnt_q;

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("ecap_budget: LIMIT must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= CNT_W'(LIMIT);
      end else if (step && cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign last = (cnt_q == CNT_W'(1));

   // R6: a response is never counted once the budget is spent
   p_budget_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |-> (cnt_q != '0))
      else $error("budget stepped past zero");

endmodule

// File: rtl/ecap_walker.sv
module ecap_walker
   import ecap_walk_pkg::*;
#(
   parameter int unsigned ADDR_W     = 12,
   parameter int unsigned WALK_LIMIT = 480
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_valid,
   input  logic [CAPID_W-1:0] start_id,
   input  logic [ADDR_W-1:0]  start_offs,
   output logic               busy,
   output logic               done,
   output logic               found,
   output logic [ADDR_W-1:0]  found_offs,
   output logic               rd_valid,
   input  logic               rd_ready,
   output logic [ADDR_W-1:0]  rd_addr,
   input  logic               rd_resp_valid,
   input  logic [HDR_W-1:0]   rd_data
);

   localparam logic [ADDR_W-1:0] FLOOR    = ADDR_W'(ECAP_FLOOR);
   localparam logic [ADDR_W-1:0] ALIGN_MSK = ~ADDR_W'(3);

   walk_state_e        state_q;
   logic [ADDR_W-1:0]  pos_q;
   logic [ADDR_W-1:0]  start_al_q;
   logic [CAPID_W-1:0] tgt_q;
   logic               first_q;
   logic               done_q;
   logic               found_q;
   logic [ADDR_W-1:0]  found_offs_q;

   logic               start_fire;
   logic [ADDR_W-1:0]  start_al;
   logic [ADDR_W-1:0]  start_pos;
   logic               resp_fire;
   logic [CAPID_W-1:0] hdr_id;
   logic [ADDR_W-1:0]  hdr_next;
   logic               hdr_empty;
   logic               budget_last;
   logic               is_hit;

   generate
      if (ADDR_W < 12) begin : g_bad_addr
         $error("ecap_walker: ADDR_W must be at least 12");
      end
      if (WALK_LIMIT < 1) begin : g_bad_budget
         $error("ecap_walker: WALK_LIMIT must be at least 1");
      end
   endgenerate

   ecap_hdr_split #(.ADDR_W(ADDR_W)) u_split (
      .word    (rd_data),
      .cap_id  (hdr_id),
      .next_al (hdr_next),
      .empty   (hdr_empty)
   );

   ecap_budget #(.LIMIT(WALK_LIMIT)) u_budget (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (start_fire),
      .step  (resp_fire),
      .last  (budget_last)
   );

   assign start_fire = start_valid && (state_q == ST_IDLE);
   assign start_al   = start_offs & ALIGN_MSK;
   assign start_pos  = (start_al < FLOOR) ? FLOOR : start_al;
   assign resp_fire  = rd_resp_valid && (state_q == ST_WAIT);
   assign is_hit     = (hdr_id == tgt_q) && (pos_q != start_al_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         pos_q        <= '0;
         start_al_q   <= '0;
         tgt_q        <= '0;
         first_q      <= 1'b0;
         done_q       <= 1'b0;
         found_q      <= 1'b0;
         found_offs_q <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start_fire) begin
                  state_q      <= ST_ISSUE;
                  pos_q        <= start_pos;
                  start_al_q   <= start_al;
                  tgt_q        <= start_id;
                  first_q      <= 1'b1;
                  done_q       <= 1'b0;
                  found_q      <= 1'b0;
                  found_offs_q <= '0;
               end
            end
            ST_ISSUE: begin
               if (rd_ready) begin
                  state_q <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (rd_resp_valid) begin
                  first_q <= 1'b0;
                  if (first_q && hdr_empty) begin
                     state_q <= ST_IDLE;
                     done_q  <= 1'b1;
                  end else if (is_hit) begin
                     state_q      <= ST_IDLE;
                     done_q       <= 1'b1;
                     found_q      <= 1'b1;
                     found_offs_q <= pos_q;
                  end else if (hdr_next < FLOOR || budget_last) begin
                     state_q <= ST_IDLE;
                     done_q  <= 1'b1;
                  end else begin
                     pos_q   <= hdr_next;
                     state_q <= ST_ISSUE;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy       = (state_q != ST_IDLE);
   assign done       = done_q;
   assign found      = found_q;
   assign found_offs = found_offs_q;
   assign rd_valid   = (state_q == ST_ISSUE);
   assign rd_addr    = pos_q;

   // R2: request holds until it is accepted
   p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)))
      else $error("read request dropped or moved");

   // R2: no second request before the response
   p_one_inflight_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && rd_ready) |=> !rd_valid)
      else $error("second read issued while one is in flight");

   // R1 / R2: every read sits in the extended area, dword aligned
   p_addr_floor_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (rd_addr >= FLOOR && rd_addr[1:0] == 2'b00))
      else $error("read address below floor or misaligned");

   // R8: result is frozen until a start is accepted
   p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !(start_valid && !busy)) |=>
         (done && $stable(found) && $stable(found_offs)))
      else $error("result changed without a new start");

   // R4: a reported hit never sits on the start offset
   p_hit_not_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
      found |-> (found_offs != start_al_q && found_offs >= FLOOR))
      else $error("hit reported at the start offset");

   // R7 / R9: busy and done are never high together
   p_busy_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done))
      else $error("busy and done both high");

endmodule

// File: tb/sim_ecap_walker.sv
module sim_ecap_walker;

   localparam int CLK_PERIOD = 10;
   localparam int AW         = 12;
   localparam int LIMIT      = 480;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_valid = 1'b0;
   logic [15:0]   start_id = '0;
   logic [AW-1:0] start_offs = '0;
   logic          busy, done, found, rd_valid;
   logic [AW-1:0] found_offs, rd_addr;
   logic          rd_ready = 1'b0;
   logic          rd_resp_valid = 1'b0;
   logic [31:0]   rd_data = '0;

   logic [31:0]   mem [0:1023];

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;
   int nreads   = 0;
   int first_addr = 0;
   int last_resp_cyc = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ecap_walker #(.ADDR_W(AW), .WALK_LIMIT(LIMIT)) u0 (
      .clk(clk), .rst_n(rst_n),
      .start_valid(start_valid), .start_id(start_id), .start_offs(start_offs),
      .busy(busy), .done(done), .found(found), .found_offs(found_offs),
      .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
      .rd_resp_valid(rd_resp_valid), .rd_data(rd_data)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] hdr(input int id, input int nxt);
      return {nxt[11:0], 4'h1, id[15:0]};
   endfunction

   task automatic clear_mem();
      for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
   endtask

   // reference walk over the memory image, from the requirements
   task automatic ref_walk(input int id, input int st, output bit f,
                           output int off, output int n);
      int sa, pos, nx;
      logic [31:0] h;
      sa  = st & ~3;
      pos = (sa < 'h100) ? 'h100 : sa;
      f = 0; off = 0;
      h = mem[pos >> 2];
      n = 1;
      if (h == 32'h0 || h == 32'hFFFF_FFFF) return;
      forever begin
         if (int'(h[15:0]) == id && pos != sa) begin
            f = 1; off = pos; return;
         end
         nx = int'(h[31:20]) & ~3;
         if (nx < 'h100) return;
         if (n == LIMIT) return;
         pos = nx;
         h = mem[pos >> 2];
         n++;
      end
   endtask

   // read port model: random ready, random response latency
   initial begin
      bit pend = 0;
      int paddr = 0;
      int lat = 0;
      forever begin
         @(negedge clk);
         cyc++;
         rd_resp_valid = 1'b0;
         if (pend) begin
            if (lat == 0) begin
               rd_resp_valid = 1'b1;
               rd_data = mem[paddr >> 2];
               last_resp_cyc = cyc;
               pend = 0;
            end else begin
               lat--;
            end
         end
         rd_ready = ($urandom % 4) != 0;
         if (rd_valid && rd_ready && rst_n) begin
            pend = 1;
            paddr = int'(rd_addr);
            lat = $urandom % 3;
            if (nreads == 0) first_addr = int'(rd_addr);
            nreads++;
         end
      end
   end

   task automatic run_walk(input int id, input int st, input bit poke, input string req);
      bit ef; int eoff, en, done_cyc, waitc, eaddr;
      ref_walk(id, st, ef, eoff, en);
      eaddr = ((st & ~3) < 'h100) ? 'h100 : (st & ~3);
      @(negedge clk);
      nreads = 0;
      start_valid = 1'b1;
      start_id = id[15:0];
      start_offs = st[AW-1:0];
      @(negedge clk);
      start_valid = 1'b0;
      chk(busy && !done, {req, " R1 busy after start"}, busy, 1);
      if (poke) begin
         @(negedge clk);
         start_valid = 1'b1;
         start_id = ~id[15:0];
         start_offs = 12'h100;
         @(negedge clk);
         start_valid = 1'b0;
      end
      waitc = 0;
      while (!done && waitc < 20000) begin
         @(negedge clk);
         waitc++;
      end
      done_cyc = cyc;
      chk(done, {req, " walk finished"}, done, 1);
      chk(first_addr == eaddr, {req, " R1 first read address"}, first_addr, eaddr);
      chk(done_cyc == last_resp_cyc + 1, {req, " R9 done timing"}, done_cyc, last_resp_cyc + 1);
      chk(!busy, {req, " R9 busy low at done"}, busy, 0);
      chk(found == ef, {req, " found"}, found, ef);
      chk(int'(found_offs) == eoff, {req, " found_offs"}, found_offs, eoff);
      chk(nreads == en, {req, " read count"}, nreads, en);
      repeat (4) @(negedge clk);
      chk(done && found == ef && int'(found_offs) == eoff,
          {req, " R8 result held"}, found_offs, eoff);
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      if (!finished) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      int offs [8];
      int k, st, tg;
      int idset [4];
      idset[0] = 16'h0010; idset[1] = 16'h0001; idset[2] = 16'h0003; idset[3] = 16'h000B;
      void'($urandom(32'h5EED_0042));
      clear_mem();
      repeat (3) @(negedge clk);
      // R8 reset state
      chk(!busy && !done && !found && !rd_valid && found_offs == '0,
          "R8 reset state", {busy, done, found, rd_valid}, 0);
      rst_n = 1'b1;

      // R3: empty list, all zeros and all ones
      clear_mem();
      run_walk(16'h0010, 0, 0, "R3 zero header");
      mem['h100 >> 2] = 32'hFFFF_FFFF;
      run_walk(16'hFFFF, 0, 0, "R3 ones header");

      // R4/R5: ID 0x0010 at second node
      clear_mem();
      mem['h100 >> 2] = hdr(16'h0001, 'h140);
      mem['h140 >> 2] = hdr(16'h0010, 'h180);
      mem['h180 >> 2] = hdr(16'h0010, 'h000);
      run_walk(16'h0010, 0, 0, "R4 find second");
      // R4: restart from previous hit finds next instance
      run_walk(16'h0010, 'h140, 0, "R4 skip start hit");
      // R4: no instance after last one
      run_walk(16'h0010, 'h180, 0, "R4 past last hit");
      // R1: low bits of start ignored, start inside area
      run_walk(16'h0010, 'h143, 0, "R1 unaligned start");
      // R7: start while busy ignored
      run_walk(16'h0010, 0, 1, "R7 start while busy");

      // R5: low pointer bits cleared; pointer below floor ends walk
      clear_mem();
      mem['h100 >> 2] = hdr(16'h0001, 'h14B);
      mem['h148 >> 2] = hdr(16'h0003, 'h0FC);
      mem['h0FC >> 2] = hdr(16'h0010, 'h000);
      run_walk(16'h0003, 0, 0, "R5 aligned next");
      run_walk(16'h0010, 0, 0, "R5 below floor");

      // R6: self loop exhausts the budget
      clear_mem();
      mem['h100 >> 2] = hdr(16'h0001, 'h100);
      run_walk(16'h0010, 0, 0, "R6 budget loop");
      run_walk(16'h0001, 'h100, 0, "R6 budget self skip");

      // random lists
      for (int t = 0; t < 40; t++) begin
         clear_mem();
         k = 1 + ($urandom % 6);
         offs[0] = 'h100;
         for (int i = 1; i < k; i++) offs[i] = offs[i-1] + 8 + 4 * ($urandom % 10);
         for (int i = 0; i < k; i++)
            mem[offs[i] >> 2] = hdr(idset[$urandom % 4], (i == k - 1) ? 0 : offs[i+1]);
         st = ($urandom % 2) ? 0 : offs[$urandom % k];
         tg = idset[$urandom % 4];
         run_walk(tg, st, ($urandom % 4) == 0, "R4 R5 random list");
      end

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule